// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper

This block regulates the winding current of one H-bridge. It reads a two-bit drive command and turns it into four registered gate enables, one high-side and one low-side switch for each of the two half-bridges. When the command is forward or reverse, the block drives the winding until an external current comparator raises its trip flag. It then stops the drive for a fixed off-time and starts a new on-phase when that time is over.

The off-time has two slices. The first quarter is fast decay, in which the opposite diagonal pair conducts. The rest is slow decay, in which both low-side switches conduct. A zero-current flag that arrives during fast decay turns all four switches off for what is left of that slice. A blanking window at the start of every on-phase masks the trip flag, and this window also sets the minimum on-time. Brake and coast are decoded directly and do not go through the chopper. All durations are parameters counted in clock cycles.

Top module: `fixed_off_chopper`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all four gate enables are 0.
- R2: The gate bits are written {hi1,lo1,hi2,lo2}. The command encodings are 2'b00 coast (0000), 2'b01 reverse (0110), 2'b10 forward (1001) and 2'b11 brake (0101). Starting from all-off, a new command reaches the gates on the second clock edge after it is sampled.
- R3: For BLANK_CYC cycles after a drive phase starts, the trip flag is ignored. A trip that is still held when blanking ends starts the off-time on the next edge.
- R4: A trip sampled after blanking starts fast decay, which drives the opposite diagonal: 0110 when forward and 1001 when reverse. Fast decay lasts OFF_CYC/4 cycles, rounded down.
- R5: Slow decay (0101) follows fast decay and lasts OFF_CYC minus the fast-decay length.
- R6: A zero-current flag sampled during fast decay sets all gates to 0 for the rest of that slice. The total off-time does not change.
- R7: At the end of the off-time, drive resumes in the same direction with a fresh blanking window.
- R8: In brake and in coast, the trip and zero-current flags have no effect on the gates.
- R9: When the command changes to forward or reverse at any point, including during the off-time, the off-time is cancelled and drive restarts in the new direction with a fresh blanking window.
- R10: The high-side and low-side enables of one half-bridge are never both 1. When the gates move from one non-zero pattern to a different one, they spend exactly one cycle at 0000 in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_cmd | input | 2 | Drive command: 00 coast, 01 reverse, 10 forward, 11 brake |
| trip | input | 1 | Current comparator flag, active high |
| zero_cur | input | 1 | Winding current has reached zero, active high |
| gate_hi1 | output | 1 | High-side enable, half-bridge 1 |
| gate_lo1 | output | 1 | Low-side enable, half-bridge 1 |
| gate_hi2 | output | 1 | High-side enable, half-bridge 2 |
| gate_lo2 | output | 1 | Low-side enable, half-bridge 2 |

## Verification
An input is sampled on one edge, where it updates the phase register. It reaches the gates on the next edge, or one edge later when a dead cycle has to be inserted between two non-zero patterns. Each scenario begins with the first clock edge after reset is released, counted as edge 0. The bench changes inputs and reads outputs on falling edges, so a value produced by edge j is read at falling edge j+1. Every expected pattern is checked at the falling edge worked out from these counts, including the short fast-decay window, the first cycle after a blanking window, and the dead cycle itself.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    DIR_COAST = 2'b00,
    DIR_REV   = 2'b01,
    DIR_FWD   = 2'b10,
    DIR_BRAKE = 2'b11
  } dir_e;

  typedef enum logic [2:0] {
    PH_HOLD,
    PH_BLANK,
    PH_ON,
    PH_FAST,
    PH_FLOAT,
    PH_SLOW
  } phase_e;

  typedef struct packed {
    logic hi1;
    logic lo1;
    logic hi2;
    logic lo2;
  } gate_t;

  localparam gate_t GATE_OFF  = 4'b0000;
  localparam gate_t GATE_FWD  = 4'b1001;
  localparam gate_t GATE_REV  = 4'b0110;
  localparam gate_t GATE_LOWS = 4'b0101;

  function automatic logic is_drive(input dir_e d);
    return (d == DIR_FWD) || (d == DIR_REV);
  endfunction

endpackage

// File: rtl/chop_timer.sv
module chop_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/chop_seq.sv
module chop_seq
  import chop_pkg::*;
#(
  parameter int BLANK_CYC = 360,
  parameter int FAST_CYC  = 1000,
  parameter int SLOW_CYC  = 3000,
  parameter int CW        = 12
) (
  input  logic   clk,
  input  logic   rst,
  input  dir_e   dir_cmd,
  input  logic   trip,
  input  logic   zero_cur,
  output phase_e phase,
  output dir_e   drive_dir
);

  localparam logic [CW-1:0] BLANK_LD = CW'(BLANK_CYC - 1);
  localparam logic [CW-1:0] FAST_LD  = CW'(FAST_CYC - 1);
  localparam logic [CW-1:0] SLOW_LD  = CW'(SLOW_CYC - 1);

  phase_e        ph_q, ph_d;
  dir_e          dir_q, dir_d;
  logic          ld;
  logic [CW-1:0] ld_val;
  logic          tmr_done;

  chop_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (ld),
    .load_val (ld_val),
    .expired  (tmr_done)
  );

  always_comb begin
    ph_d   = ph_q;
    dir_d  = dir_q;
    ld     = 1'b0;
    ld_val = '0;
    if (dir_cmd != dir_q) begin
      dir_d = dir_cmd;
      if (is_drive(dir_cmd)) begin
        ph_d   = PH_BLANK;
        ld     = 1'b1;
        ld_val = BLANK_LD;
      end else begin
        ph_d = PH_HOLD;
      end
    end else begin
      unique case (ph_q)
        PH_HOLD: ph_d = PH_HOLD;
        PH_BLANK: begin
          if (tmr_done) ph_d = PH_ON;
        end
        PH_ON: begin
          if (trip) begin
            ph_d   = PH_FAST;
            ld     = 1'b1;
            ld_val = FAST_LD;
          end
        end
        PH_FAST: begin
          if (tmr_done) begin
            ph_d   = PH_SLOW;
            ld     = 1'b1;
            ld_val = SLOW_LD;
          end else if (zero_cur) begin
            ph_d = PH_FLOAT;
          end
        end
        PH_FLOAT: begin
          if (tmr_done) begin
            ph_d   = PH_SLOW;
            ld     = 1'b1;
            ld_val = SLOW_LD;
          end
        end
        PH_SLOW: begin
          if (tmr_done) begin
            ph_d   = PH_BLANK;
            ld     = 1'b1;
            ld_val = BLANK_LD;
          end
        end
        default: ph_d = PH_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_HOLD;
      dir_q <= DIR_COAST;
    end else begin
      ph_q  <= ph_d;
      dir_q <= dir_d;
    end
  end

  assign phase     = ph_q;
  assign drive_dir = dir_q;

endmodule

// File: rtl/chop_gate_out.sv
module chop_gate_out
  import chop_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_e phase,
  input  dir_e   drive_dir,
  output gate_t  gate
);

  gate_t tgt;
  gate_t gate_q;

  always_comb begin
    tgt = GATE_OFF;
    unique case (phase)
      PH_HOLD:  tgt = (drive_dir == DIR_BRAKE) ? GATE_LOWS : GATE_OFF;
      PH_BLANK,
      PH_ON:    tgt = (drive_dir == DIR_FWD) ? GATE_FWD : GATE_REV;
      PH_FAST:  tgt = (drive_dir == DIR_FWD) ? GATE_REV : GATE_FWD;
      PH_FLOAT: tgt = GATE_OFF;
      PH_SLOW:  tgt = GATE_LOWS;
      default:  tgt = GATE_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= GATE_OFF;
    end else if ((tgt != gate_q) && (gate_q != GATE_OFF)) begin
      gate_q <= GATE_OFF;
    end else begin
      gate_q <= tgt;
    end
  end

  assign gate = gate_q;

endmodule

// File: rtl/fixed_off_chopper.sv
module fixed_off_chopper
  import chop_pkg::*;
#(
  parameter int BLANK_CYC = 360,
  parameter int OFF_CYC   = 4000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] dir_cmd,
  input  logic       trip,
  input  logic       zero_cur,
  output logic       gate_hi1,
  output logic       gate_lo1,
  output logic       gate_hi2,
  output logic       gate_lo2
);

  localparam int FAST_CYC = OFF_CYC / 4;
  localparam int SLOW_CYC = OFF_CYC - FAST_CYC;
  localparam int MAX_CYC  = (BLANK_CYC > SLOW_CYC) ? BLANK_CYC : SLOW_CYC;
  localparam int CW       = $clog2(MAX_CYC + 1);

  phase_e phase;
  dir_e   drive_dir;
  gate_t  gate;

  chop_seq #(
    .BLANK_CYC (BLANK_CYC),
    .FAST_CYC  (FAST_CYC),
    .SLOW_CYC  (SLOW_CYC),
    .CW        (CW)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .dir_cmd   (dir_e'(dir_cmd)),
    .trip      (trip),
    .zero_cur  (zero_cur),
    .phase     (phase),
    .drive_dir (drive_dir)
  );

  chop_gate_out u_out (
    .clk       (clk),
    .rst       (rst),
    .phase     (phase),
    .drive_dir (drive_dir),
    .gate      (gate)
  );

  assign gate_hi1 = gate.hi1;
  assign gate_lo1 = gate.lo1;
  assign gate_hi2 = gate.hi2;
  assign gate_lo2 = gate.lo2;

endmodule

// File: rtl/chop_chk.sv
module chop_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] dir_cmd,
  input logic       hi1,
  input logic       lo1,
  input logic       hi2,
  input logic       lo2
);

  logic       started = 1'b0;
  logic [2:0] arm     = 3'd0;
  logic [3:0] g;

  assign g = {hi1, lo1, hi2, lo2};

  always_ff @(posedge clk) begin
    started <= 1'b1;
    if (rst) arm <= 3'd0;
    else if (arm != 3'd4) arm <= arm + 3'd1;
  end

  // R1
  reset_off_chk: assert property (@(posedge clk) disable iff (!started)
    $past(rst) |-> (g == 4'b0000));

  // R10
  leg1_excl_chk: assert property (@(posedge clk) disable iff (rst || !started)
    !(hi1 && lo1));

  // R10
  leg2_excl_chk: assert property (@(posedge clk) disable iff (rst || !started)
    !(hi2 && lo2));

  // R10
  dead_gap_chk: assert property (@(posedge clk) disable iff (rst || arm == 3'd0)
    ((g != 4'b0000) && ($past(g) != 4'b0000)) |-> (g == $past(g)));

  // R8
  brake_hold_chk: assert property (@(posedge clk) disable iff (rst || arm != 3'd4)
    ((dir_cmd == 2'b11) && ($past(dir_cmd) == 2'b11) && ($past(dir_cmd, 2) == 2'b11)
     && ($past(dir_cmd, 3) == 2'b11)) |-> (g == 4'b0101));

  // R2
  coast_hold_chk: assert property (@(posedge clk) disable iff (rst || arm != 3'd4)
    ((dir_cmd == 2'b00) && ($past(dir_cmd) == 2'b00) && ($past(dir_cmd, 2) == 2'b00)
     && ($past(dir_cmd, 3) == 2'b00)) |-> (g == 4'b0000));

endmodule

bind fixed_off_chopper chop_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .dir_cmd (dir_cmd),
  .hi1     (gate_hi1),
  .lo1     (gate_lo1),
  .hi2     (gate_hi2),
  .lo2     (gate_lo2)
);

// File: tb/sim_fixed_off_chopper.sv
`timescale 1ns/1ps
module sim_fixed_off_chopper;

  localparam int BLANK = 4;
  localparam int OFFT  = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] dir_cmd = 2'b00;
  logic       trip = 1'b0;
  logic       zero_cur = 1'b0;
  logic       gate_hi1, gate_lo1, gate_hi2, gate_lo2;

  int errors = 0;
  int checks = 0;
  int n = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fixed_off_chopper #(.BLANK_CYC(BLANK), .OFF_CYC(OFFT)) u0 (
    .clk(clk), .rst(rst), .dir_cmd(dir_cmd), .trip(trip), .zero_cur(zero_cur),
    .gate_hi1(gate_hi1), .gate_lo1(gate_lo1), .gate_hi2(gate_hi2), .gate_lo2(gate_lo2)
  );

  task automatic chk(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {gate_hi1, gate_lo1, gate_hi2, gate_lo2};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at step %0d: gates=%b expected=%b", req, n, act, exp);
    end
  endtask

  task automatic go(input int k);
    while (n < k) begin
      @(negedge clk);
      n++;
    end
  endtask

  // Resets the block, then releases reset with the given inputs; that falling edge is step 0.
  task automatic start(input logic [1:0] d, input logic t);
    @(negedge clk);
    rst = 1'b1; dir_cmd = 2'b00; trip = 1'b0; zero_cur = 1'b0;
    repeat (3) @(negedge clk);
    n = 0;
    chk("R1", 4'b0000);
    rst = 1'b0; dir_cmd = d; trip = t;
  endtask

  task automatic t_forward_chop();
    start(2'b10, 1'b0);
    go(1);  chk("R1", 4'b0000);
    go(2);  chk("R2", 4'b1001); trip = 1'b1;
    go(5);  chk("R3", 4'b1001);
    go(6);  trip = 1'b0;
    go(7);  chk("R10", 4'b0000);
    go(8);  chk("R4", 4'b0110);
    go(9);  chk("R4", 4'b0110);
    go(10); chk("R10", 4'b0000);
    go(11); chk("R5", 4'b0101);
    go(18); chk("R5", 4'b0101);
    go(19); chk("R10", 4'b0000);
    go(20); chk("R7", 4'b1001);
  endtask

  task automatic t_zero_abort();
    start(2'b10, 1'b1);
    go(6);  trip = 1'b0; zero_cur = 1'b1;
    go(7);  chk("R6", 4'b0000); zero_cur = 1'b0;
    go(8);  chk("R6", 4'b0000);
    go(9);  chk("R6", 4'b0000);
    go(10); chk("R6", 4'b0101);
    go(18); chk("R6", 4'b0101);
    go(20); chk("R7", 4'b1001);
  endtask

  task automatic t_reverse_redirect();
    start(2'b01, 1'b1);
    go(2);  chk("R2", 4'b0110);
    go(8);  chk("R4", 4'b1001);
    go(9);  dir_cmd = 2'b10;
    go(10); chk("R10", 4'b0000);
    go(11); chk("R9", 4'b1001);
    go(14); chk("R9", 4'b1001);
    go(15); chk("R3", 4'b1001);
    go(16); chk("R9", 4'b0000);
    go(17); chk("R4", 4'b0110);
    trip = 1'b0;
  endtask

  task automatic t_brake_coast();
    start(2'b11, 1'b1);
    zero_cur = 1'b1;
    go(2);  chk("R2", 4'b0101);
    go(12); chk("R8", 4'b0101); dir_cmd = 2'b00;
    go(14); chk("R2", 4'b0000);
    go(20); chk("R8", 4'b0000); dir_cmd = 2'b10; trip = 1'b0; zero_cur = 1'b0;
    go(22); chk("R2", 4'b1001); dir_cmd = 2'b11;
    go(23); chk("R10", 4'b1001);
    go(24); chk("R10", 4'b0000);
    go(25); chk("R10", 4'b0101);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  initial begin
    t_forward_chop();
    t_zero_abort();
    t_reverse_redirect();
    t_brake_coast();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule